// File: doc/BRIEF.md
# Bus Slave Response Protocol Monitor

This block watches the slave-side handshake of a pipelined system bus and flags any cycle in which the response signalling breaks the transfer-completion rules. On every rising clock edge it samples the ready line, the two-bit response code and the master's two-bit transfer type. It then decides whether the slave is stalling legally, completing with a clean single-cycle acknowledge, or completing with a properly formed two-cycle error-class response. It also checks that an idle-pause (busy) transfer accepted by the slave is answered at once with a clean acknowledge.

The monitor is passive. It sits beside the bus, drives nothing onto it, and reports through two outputs. The first is a per-cycle violation code naming the rule that was broken. The second is a sticky flag that stays set until reset, so a long regression can be checked at its end. Address decode, data integrity and burst length are not examined. The reset input is asynchronous and active low. Its release passes through a short synchronizer before the monitor starts judging the bus.

Top module: `rspmon_top`

## Requirements
- R1: While reset is asserted, and after its release, the sticky flag and the violation code both read 0 until a violation is observed.
- R2: Cycles with ready low and response OKAY (code 0) inside a response window may repeat any number of times without a violation.
- R3: A response window may close in a single cycle with ready high and response OKAY, with no violation.
- R4: Responses use ERROR=1, RETRY=2 and SPLIT=3. Each one is legal when it spans two cycles with the same code, ready low in the first cycle and ready high in the second.
- R5: A non-OKAY response with ready high in the first cycle of a response gives violation code 1.
- R6: A second cycle whose response code differs from the first gives violation code 2.
- R7: A second cycle that keeps the same non-OKAY code but has ready low gives violation code 3.
- R8: Transfer types are IDLE=0, BUSY=1, NONSEQ=2 and SEQ=3. If ready is high while the type is BUSY, the next cycle must have ready high and response OKAY. Otherwise the monitor gives violation code 4.
- R9: The violation code shows the result for the sampled cycle one clock edge later, and reads 0 for legal cycles. When several rules fail in the same cycle, the lowest code is reported.
- R10: The sticky flag rises with the first non-zero violation code and stays high until reset.
- R11: After any second cycle, the window stays open if ready was low and closes if ready was high. After a code-1 violation, the next cycle starts a fresh window.
- R12: Asserting reset clears the flag and the code at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ready_i | input | 1 | Slave ready / transfer-done line |
| resp_i | input | 2 | Slave response code (OKAY=0, ERROR=1, RETRY=2, SPLIT=3) |
| trans_i | input | 2 | Master transfer type (IDLE=0, BUSY=1, NONSEQ=2, SEQ=3) |
| viol_flag_o | output | 1 | Sticky violation flag |
| viol_code_o | output | 3 | Violation code for the previous sampled cycle, 0 if legal |

## Verification
The bench drives long runs of legal stalls and each of the three two-cycle responses. A monitor that mistook a stall for a first response cycle would raise false alarms there. It then corrupts second cycles in two ways: it swaps the code, and it drops ready. A design that confused the two would report the wrong code, and one that forgot the captured code would miss the swap entirely. Busy transfers are followed by a stall, by a clean acknowledge, and by an early error. The last case exposes a priority mix-up between code 1 and code 4. A mid-run asynchronous reset shows whether the sticky flag really clears without a clock.

// File: rtl/rspmon_pkg.sv
`timescale 1ns/1ps
package rspmon_pkg;

  localparam int RESP_W  = 2;
  localparam int TRANS_W = 2;
  localparam int CODE_W  = 3;

  typedef enum logic [RESP_W-1:0] {
    RSP_OKAY  = 2'd0,
    RSP_ERROR = 2'd1,
    RSP_RETRY = 2'd2,
    RSP_SPLIT = 2'd3
  } resp_e;

  typedef enum logic [TRANS_W-1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  // Window tracker states: open (fresh window), stall (waiting), tail (second cycle due)
  typedef enum logic [1:0] {
    ST_OPEN  = 2'd0,
    ST_STALL = 2'd1,
    ST_TAIL  = 2'd2
  } win_e;

  // Lower value wins when several rules fail together
  typedef enum logic [CODE_W-1:0] {
    VC_NONE     = 3'd0,
    VC_EARLY    = 3'd1,
    VC_CHANGE   = 3'd2,
    VC_TAIL_LOW = 3'd3,
    VC_BUSY     = 3'd4
  } vcode_e;

endpackage

// File: rtl/rspmon_rstsync.sv
`timescale 1ns/1ps
module rspmon_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift a constant one in; assertion is asynchronous, release takes STAGES edges
  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/rspmon_window.sv
`timescale 1ns/1ps
module rspmon_window
  import rspmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic [RESP_W-1:0] resp_i,
  output vcode_e            code_o,
  output logic              in_tail_o
);

  win_e  state_q, state_d;
  resp_e held_q, held_d;
  logic  held_en;

  // Next-state and per-cycle verdict
  always_comb begin
    state_d = state_q;
    held_d  = held_q;
    held_en = 1'b0;
    code_o  = VC_NONE;
    case (state_q)
      ST_TAIL: begin
        if (resp_e'(resp_i) != held_q) code_o = VC_CHANGE;
        else if (!ready_i)             code_o = VC_TAIL_LOW;
        state_d = ready_i ? ST_OPEN : ST_STALL;
      end
      default: begin
        if (resp_e'(resp_i) == RSP_OKAY) begin
          state_d = ready_i ? ST_OPEN : ST_STALL;
        end else if (!ready_i) begin
          state_d = ST_TAIL;
          held_d  = resp_e'(resp_i);
          held_en = 1'b1;
        end else begin
          code_o  = VC_EARLY;
          state_d = ST_OPEN;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OPEN;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_q <= RSP_OKAY;
    else if (held_en) held_q <= held_d;
  end

  assign in_tail_o = (state_q == ST_TAIL);

endmodule

// File: rtl/rspmon_busy.sv
`timescale 1ns/1ps
module rspmon_busy
  import rspmon_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ready_i,
  input  logic [RESP_W-1:0]  resp_i,
  input  logic [TRANS_W-1:0] trans_i,
  output logic               viol_o,
  output logic               pend_o
);

  logic pend_q, pend_d;

  always_comb begin
    pend_d = ready_i && (trans_e'(trans_i) == TR_BUSY);
    viol_o = pend_q && !(ready_i && (resp_e'(resp_i) == RSP_OKAY));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/rspmon_report.sv
`timescale 1ns/1ps
module rspmon_report
  import rspmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  vcode_e            win_code_i,
  input  logic              busy_viol_i,
  output logic              flag_o,
  output logic [CODE_W-1:0] code_o
);

  vcode_e code_d, code_q;
  logic   flag_q, flag_set;

  always_comb begin
    if (win_code_i != VC_NONE) code_d = win_code_i;
    else if (busy_viol_i)      code_d = VC_BUSY;
    else                       code_d = VC_NONE;
    flag_set = (code_d != VC_NONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= VC_NONE;
    else         code_q <= code_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (flag_set) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
  assign code_o = code_q;

endmodule

// File: rtl/rspmon_top.sv
`timescale 1ns/1ps
module rspmon_top
  import rspmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ready_i,
  input  logic [RESP_W-1:0]  resp_i,
  input  logic [TRANS_W-1:0] trans_i,
  output logic               viol_flag_o,
  output logic [CODE_W-1:0]  viol_code_o
);

  logic   rst_int_n;
  vcode_e win_code;
  logic   in_tail;
  logic   busy_viol;
  logic   busy_pend;

  rspmon_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  rspmon_window u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .ready_i   (ready_i),
    .resp_i    (resp_i),
    .code_o    (win_code),
    .in_tail_o (in_tail)
  );

  rspmon_busy u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .ready_i (ready_i),
    .resp_i  (resp_i),
    .trans_i (trans_i),
    .viol_o  (busy_viol),
    .pend_o  (busy_pend)
  );

  rspmon_report u_rep (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .win_code_i  (win_code),
    .busy_viol_i (busy_viol),
    .flag_o      (viol_flag_o),
    .code_o      (viol_code_o)
  );

endmodule

// File: rtl/rspmon_chk.sv
`timescale 1ns/1ps
module rspmon_chk (
  input logic       clk_i,
  input logic       rst_int_n,
  input logic       ready_i,
  input logic [1:0] resp_i,
  input logic [1:0] trans_i,
  input logic       in_tail,
  input logic       busy_pend,
  input logic       viol_flag_o,
  input logic [2:0] viol_code_o
);

  logic unused_trans;
  assign unused_trans = ^trans_i;

  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    viol_code_o <= 3'd4); // R9

  AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    viol_flag_o |=> viol_flag_o); // R10

  AST_CODE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (viol_code_o != 3'd0) |-> viol_flag_o); // R10

  AST_EARLY_CODE: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (!in_tail && ready_i && resp_i != 2'd0) |=> (viol_code_o == 3'd1)); // R5

  AST_WAIT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (!in_tail && !busy_pend && !ready_i && resp_i == 2'd0) |=> (viol_code_o == 3'd0)); // R2

  AST_BUSY_STALL: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (busy_pend && !in_tail && !ready_i && resp_i == 2'd0) |=> (viol_code_o == 3'd4)); // R8

  AST_TAIL_SWAP: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (in_tail && $past(!in_tail) && resp_i != $past(resp_i)) |=> (viol_code_o == 3'd2)); // R6

endmodule

bind rspmon_top rspmon_chk u_chk (
  .clk_i       (clk_i),
  .rst_int_n   (rst_int_n),
  .ready_i     (ready_i),
  .resp_i      (resp_i),
  .trans_i     (trans_i),
  .in_tail     (in_tail),
  .busy_pend   (busy_pend),
  .viol_flag_o (viol_flag_o),
  .viol_code_o (viol_code_o)
);

// File: tb/sim_rspmon_top.sv
`timescale 1ns/1ps
module sim_rspmon_top;

  logic       clk;
  logic       rst_n;
  logic       ready;
  logic [1:0] resp;
  logic [1:0] trans;
  logic       flag;
  logic [2:0] code;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference model state
  bit       m_tail;
  bit [1:0] m_held;
  bit       m_pend;
  bit       m_flag;

  rspmon_top #(.SYNC_STAGES(2)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ready_i     (ready),
    .resp_i      (resp),
    .trans_i     (trans),
    .viol_flag_o (flag),
    .viol_code_o (code)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int expect_code(bit tail, bit [1:0] held, bit pend,
                                     bit r, bit [1:0] p);
    int c = 0;
    if (tail) begin
      if (p != held) c = 2;
      else if (!r)   c = 3;
    end else if (r && p != 2'd0) begin
      c = 1;
    end
    if (c == 0 && pend && !(r && p == 2'd0)) c = 4;
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  endtask

  // Drive one cycle at a falling edge, check its verdict at the next falling edge
  task automatic step(bit r, bit [1:0] p, bit [1:0] t, string req);
    int e;
    e = expect_code(m_tail, m_held, m_pend, r, p);
    if (m_tail) m_tail = 0;
    else if (p != 2'd0 && !r) begin m_tail = 1; m_held = p; end
    m_pend = r && (t == 2'd1);
    if (e != 0) m_flag = 1;
    ready = r; resp = p; trans = t;
    @(negedge clk);
    chk(req, int'(code), e);
    chk({req, " flag"}, int'(flag), int'(m_flag));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ready = 1'b1; resp = 2'd0; trans = 2'd0;
    m_tail = 0; m_held = 0; m_pend = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    chk("R1 code in reset", int'(code), 0);
    chk("R1 flag in reset", int'(flag), 0);
    rst_n = 1'b1;
    repeat (3) step(1, 2'd0, 2'd0, "R1");
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'h5EED_0C0D));
    @(negedge clk);
    do_reset();

    // R2 stalls then R3 clean completion
    repeat (6) step(0, 2'd0, 2'd2, "R2");
    step(1, 2'd0, 2'd2, "R3");
    step(1, 2'd0, 2'd3, "R3");

    // R4 legal two-cycle responses
    for (int k = 1; k < 4; k++) begin
      step(0, 2'(k), 2'd2, "R4");
      step(1, 2'(k), 2'd0, "R4");
    end
    step(0, 2'd0, 2'd0, "R2");
    step(0, 2'd2, 2'd0, "R4");
    step(1, 2'd2, 2'd0, "R4");

    // R5 early response, then R11 fresh window
    step(1, 2'd1, 2'd2, "R5");
    step(0, 2'd1, 2'd2, "R11");
    step(1, 2'd1, 2'd2, "R11");

    // R6 swapped code, R7 tail with ready low, R11 window stays open
    step(0, 2'd1, 2'd0, "R6");
    step(1, 2'd3, 2'd0, "R6");
    step(0, 2'd2, 2'd0, "R7");
    step(0, 2'd2, 2'd0, "R7");
    step(0, 2'd0, 2'd0, "R11");
    step(1, 2'd0, 2'd0, "R11");

    // R8 busy rule
    step(1, 2'd0, 2'd1, "R8");
    step(0, 2'd0, 2'd0, "R8");
    step(1, 2'd0, 2'd0, "R8");
    step(1, 2'd0, 2'd1, "R8");
    step(1, 2'd0, 2'd2, "R8");
    // R9 priority: early response beats busy rule
    step(1, 2'd0, 2'd1, "R9");
    step(1, 2'd3, 2'd0, "R9");
    step(1, 2'd0, 2'd1, "R9");
    step(0, 2'd1, 2'd0, "R9");
    step(1, 2'd1, 2'd0, "R9");

    // R12 asynchronous clear with the flag set
    chk("R10 flag held", int'(flag), 1);
    #2 rst_n = 1'b0;
    #1;
    chk("R12 flag cleared", int'(flag), 0);
    chk("R12 code cleared", int'(code), 0);
    @(negedge clk);
    do_reset();

    // Mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      bit       r;
      bit [1:0] p;
      bit [1:0] t;
      r = ($urandom_range(0, 9) < 6);
      p = ($urandom_range(0, 9) < 7) ? 2'd0 : 2'($urandom_range(1, 3));
      if (m_tail && $urandom_range(0, 9) < 7) begin r = 1; p = m_held; end
      t = 2'($urandom_range(0, 3));
      step(r, p, t, "R9");
    end
    chk("R10 flag after random", int'(flag), int'(m_flag));

    report();
  end

endmodule